// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block produces the bit timing of a CAN controller from the system clock. A prescaler divides the clock into time quanta. A sequencer then steps each bit through four segments: a one-quantum synchronisation segment, a propagation segment, a first phase segment and a second phase segment. It emits a one-cycle transmit-point strobe where each bit begins and a one-cycle sample strobe where the first phase segment ends. The frame logic uses the first to launch the next transmit bit and the second to capture the receive line.

Five fields set the timing: the prescaler, the three variable segment lengths and the jump width. Each field encodes its length minus one. With a prescaler of zero, one quantum moves from the second phase segment to the first, so the sample strobe falls one quantum later while the bit length does not change. An illegal setting raises an error flag and holds the sequencer idle. On a recessive-to-dominant edge of the receive line, the block either restarts the bit (bus idle) or corrects the current bit by a bounded amount (during a frame).

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts brp_i+1 clock cycles, and quantum boundaries are counted from the first clock of the bit.
- R2: A bit is 1 quantum of sync, prs_i+1 quanta of propagation, phs1_i+1 quanta of phase one and phs2_i+1 quanta of phase two, when no resynchronisation takes place.
- R3: When brp_i is 0, phase one lasts phs1_i+2 quanta and phase two lasts phs2_i quanta. The bit length is unchanged.
- R4: sample_o is a one-cycle pulse on the last clock of phase one, and phase two follows it.
- R5: tx_pt_o is a one-cycle pulse on the first clock of the sync segment, that is, on the first clock of every bit.
- R6: cfg_err_o is 1 when the bit totals fewer than 8 or more than 25 quanta, or when brp_i is 0 and phs2_i is 0. While it is 1, sample_o and tx_pt_o stay 0.
- R7: Out of reset, sample_o and tx_pt_o are 0 and cfg_err_o is 1 until the fields are first loaded. While en_i is 0, no strobe appears. The first clock with en_i at 1 is a transmit point.
- R8: With idle_i at 1, a falling edge on rx_i (1 in the previous cycle, 0 now) makes the next cycle the first clock of a new bit.
- R9: With idle_i at 0, a falling edge in the propagation segment or in phase one lengthens phase one by min(e, sjw_i+1) quanta. Here e counts the quanta from the end of sync up to and including the quantum that holds the edge.
- R10: With idle_i at 0, a falling edge in quantum k (counted from 0) of phase two ends phase two after max(k+1, L-(sjw_i+1)) quanta, where L is the length of phase two.
- R11: Edges inside the sync segment cause no correction, and only the first edge of a bit causes one.
- R12: Field changes take effect at the next bit boundary. The fields are reloaded on every clock while the block is disabled or in error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; 0 holds the sequencer idle |
| idle_i | input | 1 | Bus idle from frame logic; selects hard synchronisation |
| rx_i | input | 1 | Receive line, 0 is dominant |
| brp_i | input | 6 | Prescaler field |
| prs_i | input | 3 | Propagation segment field |
| phs1_i | input | 3 | Phase one field |
| phs2_i | input | 3 | Phase two field |
| sjw_i | input | 2 | Jump width field |
| sample_o | output | 1 | Sample-point strobe |
| tx_pt_o | output | 1 | Transmit-point strobe |
| cfg_err_o | output | 1 | Illegal timing setting |

## Verification
Both strobes and cfg_err_o are combinational from registered state. A transmit point therefore appears in the same cycle that en_i rises, and a field write made while the block is disabled shows on cfg_err_o one clock later. An rx_i edge driven during clock c is registered at the end of that clock. A hard synchronisation therefore puts the transmit point at c+1, and a resynchronisation changes the segment that is running in clock c. The bench numbers clocks from the enable cycle and drives its stimulus just after a rising edge. It samples on the falling edge and records the clock index of every strobe, then compares those indices with positions worked out by hand from the segment lengths.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_W  = 6;
  localparam int SEG_W  = 3;
  localparam int SJW_W  = 2;
  localparam int LEN_W  = 5;
  localparam int EXT_W  = SJW_W + 1;
  localparam int MIN_TQ = 8;
  localparam int MAX_TQ = 25;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  typedef enum logic [1:0] {SEG_SYNC, SEG_PROP, SEG_PH1, SEG_PH2} seg_e;

  typedef struct packed {
    logic [BRP_W-1:0] brp;
    logic [LEN_W-1:0] prop_len;
    logic [LEN_W-1:0] ph1_len;
    logic [LEN_W-1:0] ph2_len;
    logic [EXT_W-1:0] sjw_len;
  } bt_cfg_t;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [SEG_W-1:0] prs_i,
  input  logic [SEG_W-1:0] phs1_i,
  input  logic [SEG_W-1:0] phs2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output bt_cfg_t          cfg_o,
  output logic             err_o
);
  bt_cfg_t          cfg_d, cfg_q;
  logic             brp_zero, err_d, err_q;
  logic [LEN_W-1:0] total;

  assign brp_zero = (brp_i == '0);

  always_comb begin
    cfg_d.brp      = brp_i;
    cfg_d.prop_len = LEN_W'(prs_i) + LEN_ONE;
    // zero prescaler: move one quantum from phase two into phase one
    cfg_d.ph1_len  = LEN_W'(phs1_i) + LEN_ONE + LEN_W'(brp_zero);
    cfg_d.ph2_len  = LEN_W'(phs2_i) + LEN_ONE - LEN_W'(brp_zero);
    cfg_d.sjw_len  = EXT_W'(sjw_i) + EXT_W'(1);
    total = LEN_ONE + cfg_d.prop_len + cfg_d.ph1_len + cfg_d.ph2_len;
    err_d = (total < LEN_W'(MIN_TQ)) || (total > LEN_W'(MAX_TQ)) ||
            (brp_zero && (phs2_i == '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b1;
    end else if (load_i) begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tick_o,
  output logic             first_o,
  output logic [BRP_W-1:0] cnt_o
);
  logic [BRP_W-1:0] cnt_q;

  assign tick_o  = run_i && (cnt_q == brp_i);
  assign first_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (tick_o)               cnt_q <= '0;
    else                           cnt_q <= cnt_q + BRP_W'(1);
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             first_i,
  input  logic             hsync_i,
  input  logic             edge_i,
  input  bt_cfg_t          cfg_i,
  output logic             sample_o,
  output logic             tx_pt_o,
  output logic             bit_end_o,
  output seg_e             seg_o,
  output logic [EXT_W-1:0] ext_o
);
  seg_e             seg_q, seg_nx;
  logic [LEN_W-1:0] cnt_q, cnt_inc, sjw_len, q_err, step, ph2_floor, alt;
  logic [LEN_W-1:0] ph1_now, ph2_now, seg_len, cut_len_q;
  logic [EXT_W-1:0] ext_q;
  logic             cut_q, synced_q, resync, early, seg_done;

  assign sjw_len = LEN_W'(cfg_i.sjw_len);
  assign cnt_inc = cnt_q + LEN_ONE;
  assign early   = (seg_q == SEG_PROP) || (seg_q == SEG_PH1);
  assign resync  = run_i && edge_i && !synced_q && (seg_q != SEG_SYNC);

  always_comb begin
    q_err     = (seg_q == SEG_PROP) ? cnt_inc : cfg_i.prop_len + cnt_inc;
    step      = (q_err < sjw_len) ? q_err : sjw_len;
    ph2_floor = (cfg_i.ph2_len > sjw_len) ? cfg_i.ph2_len - sjw_len : '0;
    alt       = (cnt_inc > ph2_floor) ? cnt_inc : ph2_floor;
    ph1_now   = cfg_i.ph1_len + LEN_W'(ext_q) + ((resync && early) ? step : '0);
    ph2_now   = (resync && seg_q == SEG_PH2) ? alt :
                (cut_q ? cut_len_q : cfg_i.ph2_len);
    unique case (seg_q)
      SEG_SYNC: begin seg_len = LEN_ONE;        seg_nx = SEG_PROP; end
      SEG_PROP: begin seg_len = cfg_i.prop_len; seg_nx = SEG_PH1;  end
      SEG_PH1:  begin seg_len = ph1_now;        seg_nx = SEG_PH2;  end
      default:  begin seg_len = ph2_now;        seg_nx = SEG_SYNC; end
    endcase
  end

  assign seg_done  = tick_i && (cnt_q == seg_len - LEN_ONE);
  assign sample_o  = seg_done && (seg_q == SEG_PH1);
  assign bit_end_o = seg_done && (seg_q == SEG_PH2);
  assign tx_pt_o   = run_i && (seg_q == SEG_SYNC) && first_i;
  assign seg_o     = seg_q;
  assign ext_o     = ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_SYNC; cnt_q <= '0; ext_q <= '0;
      cut_q <= 1'b0; cut_len_q <= '0; synced_q <= 1'b0;
    end else if (!run_i || hsync_i) begin
      seg_q <= SEG_SYNC; cnt_q <= '0; ext_q <= '0;
      cut_q <= 1'b0; synced_q <= 1'b0;
    end else begin
      if (resync) begin
        synced_q <= 1'b1;
        if (early) ext_q <= ext_q + EXT_W'(step);
        else begin
          cut_q     <= 1'b1;
          cut_len_q <= alt;
        end
      end
      if (seg_done) begin
        cnt_q <= '0;
        seg_q <= seg_nx;
        if (seg_q == SEG_PH2) begin
          ext_q <= '0; cut_q <= 1'b0; synced_q <= 1'b0;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             idle_i,
  input  logic             rx_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [SEG_W-1:0] prs_i,
  input  logic [SEG_W-1:0] phs1_i,
  input  logic [SEG_W-1:0] phs2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_o,
  output logic             tx_pt_o,
  output logic             cfg_err_o
);
  bt_cfg_t          cfg_q;
  seg_e             seg;
  logic             rx_q, fall, run, hsync, load, bit_end, tick, first;
  logic [BRP_W-1:0] presc_cnt;
  logic [EXT_W-1:0] ph1_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  assign fall  = rx_q && !rx_i;
  assign run   = en_i && !cfg_err_o;
  assign hsync = run && idle_i && fall;
  assign load  = !run || bit_end;

  can_bt_cfg i_cfg (
    .clk_i, .rst_ni, .load_i(load), .brp_i, .prs_i, .phs1_i, .phs2_i, .sjw_i,
    .cfg_o(cfg_q), .err_o(cfg_err_o)
  );

  can_bt_presc i_presc (
    .clk_i, .rst_ni, .run_i(run), .restart_i(hsync), .brp_i(cfg_q.brp),
    .tick_o(tick), .first_o(first), .cnt_o(presc_cnt)
  );

  can_bt_seq i_seq (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick), .first_i(first),
    .hsync_i(hsync), .edge_i(fall && !idle_i), .cfg_i(cfg_q),
    .sample_o, .tx_pt_o, .bit_end_o(bit_end), .seg_o(seg), .ext_o(ph1_ext)
  );
endmodule

// File: rtl/can_bt_chk.sv
module can_bt_chk
  import can_bt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             sample_o,
  input logic             tx_pt_o,
  input logic             cfg_err_o,
  input logic             hsync,
  input seg_e             seg,
  input logic [BRP_W-1:0] presc_cnt,
  input logic [EXT_W-1:0] ph1_ext,
  input bt_cfg_t          cfg_q
);
  p_presc_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_cnt <= cfg_q.brp);

  p_sample_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  p_sample_to_ph2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && en_i && !hsync) |=> (seg == SEG_PH2));

  p_tx_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pt_o && !hsync) |=> !tx_pt_o);

  p_err_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!sample_o && !tx_pt_o));

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && tx_pt_o));

  p_ext_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph1_ext <= cfg_q.sjw_len);
endmodule

bind can_bit_timing can_bt_chk i_can_bt_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sample_o(sample_o),
  .tx_pt_o(tx_pt_o), .cfg_err_o(cfg_err_o), .hsync(hsync), .seg(seg),
  .presc_cnt(presc_cnt), .ph1_ext(ph1_ext), .cfg_q(cfg_q)
);

// File: tb/test_can_bit_timing.sv
module test_can_bit_timing;
  logic       clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, idle_i = 1'b0, rx_i = 1'b1;
  logic [5:0] brp_i = '0;
  logic [2:0] prs_i = '0, phs1_i = '0, phs2_i = '0;
  logic [1:0] sjw_i = '0;
  logic       sample_o, tx_pt_o, cfg_err_o;

  int checks = 0, failures = 0;
  int s_at [4], t_at [4];
  int s_n, t_n;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  can_bit_timing i_can_bit_timing (
    .clk_i, .rst_ni, .en_i, .idle_i, .rx_i, .brp_i, .prs_i, .phs1_i,
    .phs2_i, .sjw_i, .sample_o, .tx_pt_o, .cfg_err_o
  );

  typedef struct packed {
    logic [5:0]  brp;
    logic [2:0]  prs;
    logic [2:0]  ph1;
    logic [2:0]  ph2;
    logic [10:0] period;
    logic [9:0]  sp;
    logic        err;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{6'd1,  3'd1, 3'd2, 3'd1, 11'd16,  10'd11,  1'b0},
    '{6'd0,  3'd1, 3'd2, 3'd1, 11'd8,   10'd6,   1'b0},
    '{6'd3,  3'd7, 3'd7, 3'd7, 11'd100, 10'd67,  1'b0},
    '{6'd0,  3'd2, 3'd1, 3'd1, 11'd8,   10'd6,   1'b0},
    '{6'd2,  3'd1, 3'd1, 3'd1, 11'd0,   10'd0,   1'b1},
    '{6'd0,  3'd7, 3'd7, 3'd0, 11'd0,   10'd0,   1'b1},
    '{6'd5,  3'd0, 3'd3, 3'd2, 11'd54,  10'd35,  1'b0},
    '{6'd63, 3'd1, 3'd2, 3'd1, 11'd512, 10'd383, 1'b0},
    '{6'd1,  3'd2, 3'd1, 3'd1, 11'd16,  10'd11,  1'b0}
  };

  task automatic check_int(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic start(input int b, input int p, input int f1, input int f2,
                       input int j, input logic idl);
    @(posedge clk_i); #1;
    en_i = 1'b0; rx_i = 1'b1; idle_i = idl;
    brp_i = 6'(b); prs_i = 3'(p); phs1_i = 3'(f1); phs2_i = 3'(f2); sjw_i = 2'(j);
    repeat (3) @(posedge clk_i);
    #1;
  endtask

  // clock index 0 is the enable cycle; stimulus applied just after the rising edge
  task automatic capture(input int n, input int fa, input int ra, input int fb,
                         input int chg);
    s_n = 0; t_n = 0;
    for (int i = 0; i < 4; i++) begin s_at[i] = -1; t_at[i] = -1; end
    for (int c = 0; c < n; c++) begin
      if (c == 0) en_i = 1'b1;
      if (c == fa || c == fb) rx_i = 1'b0;
      if (c == ra) rx_i = 1'b1;
      if (c == chg) prs_i = 3'd3;
      @(negedge clk_i);
      if (sample_o) begin if (s_n < 4) s_at[s_n] = c; s_n++; end
      if (tx_pt_o)  begin if (t_n < 4) t_at[t_n] = c; t_n++; end
      @(posedge clk_i); #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    // R7 reset state
    repeat (2) @(negedge clk_i);
    check_int("R7 reset sample_o", int'(sample_o), 0);
    check_int("R7 reset tx_pt_o", int'(tx_pt_o), 0);
    check_int("R7 reset cfg_err_o", int'(cfg_err_o), 1);
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // vector table: R1 R2 R3 R4 R5 R6
    foreach (VEC[v]) begin
      start(int'(VEC[v].brp), int'(VEC[v].prs), int'(VEC[v].ph1), int'(VEC[v].ph2), 0, 1'b0);
      check_int($sformatf("R6 vec%0d cfg_err_o", v), int'(cfg_err_o), int'(VEC[v].err));
      if (VEC[v].err) begin
        capture(40, -1, -1, -1, -1);
        check_int($sformatf("R6 vec%0d sample count", v), s_n, 0);
        check_int($sformatf("R6 vec%0d tx count", v), t_n, 0);
      end else begin
        capture(2 * int'(VEC[v].period) + 1, -1, -1, -1, -1);
        check_int($sformatf("R5 vec%0d first tx", v), t_at[0], 0);
        check_int($sformatf("R1 R2 vec%0d bit period", v), t_at[1], int'(VEC[v].period));
        check_int($sformatf("R3 R4 vec%0d sample point", v), s_at[0], int'(VEC[v].sp));
        check_int($sformatf("R4 vec%0d second sample", v), s_at[1],
                  int'(VEC[v].sp) + int'(VEC[v].period));
        check_int($sformatf("R4 vec%0d sample count", v), s_n, 2);
        check_int($sformatf("R5 vec%0d tx count", v), t_n, 3);
      end
    end

    // R7 disabled: no strobes with a legal setting
    start(1, 1, 2, 1, 0, 1'b0);
    begin
      int hits = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk_i);
        if (sample_o || tx_pt_o) hits++;
      end
      check_int("R7 strobes while disabled", hits, 0);
    end

    // R8 hard sync: edge in clock 5 makes clock 6 a bit start
    start(1, 1, 2, 1, 0, 1'b1);
    capture(30, 5, -1, -1, -1);
    check_int("R8 restart tx", t_at[1], 6);
    check_int("R8 sample after restart", s_at[0], 17);
    check_int("R8 next tx", t_at[2], 22);

    // resync: prop 3, ph1 4, ph2 3 (brp 0); nominal sample 7, tx 11
    start(0, 2, 2, 3, 1, 1'b0);
    capture(20, 2, 6, -1, -1);
    check_int("R9 lengthen by 2 sample", s_at[0], 9);
    check_int("R9 lengthen by 2 tx", t_at[1], 13);

    start(0, 2, 2, 3, 1, 1'b0);
    capture(20, 1, 6, -1, -1);
    check_int("R9 lengthen by 1 sample", s_at[0], 8);
    check_int("R9 lengthen by 1 tx", t_at[1], 12);

    start(0, 2, 2, 3, 1, 1'b0);
    capture(20, 5, 8, -1, -1);
    check_int("R9 capped lengthen sample", s_at[0], 9);
    check_int("R9 capped lengthen tx", t_at[1], 13);

    start(0, 2, 2, 3, 0, 1'b0);
    capture(20, 8, 12, -1, -1);
    check_int("R10 capped shorten sample", s_at[0], 7);
    check_int("R10 capped shorten tx", t_at[1], 10);

    start(0, 2, 2, 3, 3, 1'b0);
    capture(20, 8, 12, -1, -1);
    check_int("R10 full shorten tx", t_at[1], 9);

    // R11: edge in sync ignored
    start(0, 2, 2, 3, 3, 1'b0);
    capture(20, 0, 3, -1, -1);
    check_int("R11 sync edge sample", s_at[0], 7);
    check_int("R11 sync edge tx", t_at[1], 11);

    // R11: second edge in same bit ignored
    start(0, 2, 2, 3, 3, 1'b0);
    capture(20, 2, 3, 5, -1);
    check_int("R11 second edge sample", s_at[0], 9);
    check_int("R11 second edge tx", t_at[1], 13);

    // R12: prs change in clock 3 waits for the bit boundary
    start(0, 1, 1, 2, 0, 1'b0);
    capture(20, -1, -1, -1, 3);
    check_int("R12 old bit sample", s_at[0], 5);
    check_int("R12 old bit tx", t_at[1], 8);
    check_int("R12 new bit sample", s_at[1], 15);
    check_int("R12 new bit tx", t_at[2], 18);

    finish_run();
  end
endmodule